// File: doc/BRIEF.md
# Toggle-Handshake Load/Store Sequencer

This block runs single-word memory operations against a small stack RAM that it contains. Commands arrive one at a time on a valid/ready interface. Each command carries a kind (load or store), a word address, 32-bit write data and a destination register index. A store puts the data into the RAM. A load copies the addressed word into one entry of a small register file. The register file can be read at any time through a combinational read port.

The controller and register file work on the rising clock edge. The RAM array and its read-data register work on the falling edge. The controller starts an access by inverting a request bit that it owns. The RAM serves the access at the next falling edge and then copies that bit into its own acknowledge bit. The RAM therefore switches itself off after every access, and no signal has two drivers. Because of the half-cycle offset, a store completes one cycle after it is accepted and a load completes two cycles after it is accepted.

Top module: `toggle_seq_top`

## Requirements
- R1: After reset, `busy` and `done` are 0, `cmdReady` is 1, and every register file entry reads 0.
- R2: `cmdReady` is 1 only while the sequencer is idle. While `busy` is 1, `cmdReady` is 0 and commands are not taken.
- R3: A store (`cmdIsStore`=1) accepted at rising edge N has `busy`=1 after edge N. After edge N+1 it has `busy`=0 and `done`=1.
- R4: A load (`cmdIsStore`=0) accepted at edge N has `busy`=1 after edges N and N+1. After edge N+2 it has `busy`=0 and `done`=1, and register `cmdDest` holds the addressed word.
- R5: The RAM serves exactly one access for each request. At every rising edge its acknowledge bit equals the request bit. Values placed on the command inputs while `cmdValid` is 0 do not change memory.
- R6: A load returns the word most recently stored at that in-range address.
- R7: A load accepted in the first cycle after a store to the same address returns the newly stored word.
- R8: A store to an address at or above DEPTH changes no memory word. A load from such an address writes 0 to its destination register. Both keep the timing of R3 and R4.
- R9: A load changes only the register named by `cmdDest`. All other register file entries keep their values.
- R10: `done` is high for exactly one cycle per completed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the control logic uses the rising edge and the RAM uses the falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | A command is present on the command inputs |
| cmdReady | output | 1 | The sequencer is idle and takes the command at this edge |
| cmdIsStore | input | 1 | 1 for a store, 0 for a load |
| cmdAddr | input | ADDR_W | Word address |
| cmdWdata | input | 32 | Store data |
| cmdDest | input | IDX_W | Destination register for a load |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse after a command completes |
| rfIdx | input | IDX_W | Register file read index |
| rfData | output | 32 | Register file word selected by `rfIdx` |

## Verification
The assertions assume that `rstN` is released away from clock edges. They also assume that `cmdValid` is sampled only on rising edges, so command fields need to be stable only around those edges. The request and acknowledge bits are compared at rising edges only, and every request lasts at least one full cycle. The bench changes inputs a quarter period after each rising edge and never releases reset near a falling edge. Its random addresses include out-of-range values, and it seeds the memory before any load reads an address.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_ST_ACT = 2'd1,
    S_LD_ACT = 2'd2,
    S_LD_CAP = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;    // flip request bit, latch command fields
    logic isStore;  // kind of the issued command
    logic capture;  // copy RAM read word into register file
  } seqStrobe_t;
endpackage

// File: rtl/seq_stack_ram.sv
module seq_stack_ram #(
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqBit,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [seq_pkg::WORD_W-1:0] wdata,
  output logic [seq_pkg::WORD_W-1:0] rdData
);
  import seq_pkg::*;

  logic              ackBit;
  logic              active;
  logic              inRange;
  logic [WORD_W-1:0] mem [DEPTH];

  assign active  = (ackBit != reqBit);
  assign inRange = ({1'b0, addr} < (ADDR_W + 1)'(DEPTH));

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      ackBit <= 1'b0;
      rdData <= '0;
    end else if (active) begin
      ackBit <= reqBit;
      if (!wrEn) rdData <= inRange ? mem[addr] : '0;
    end
  end

  always_ff @(negedge clk) begin
    if (active && wrEn && inRange) mem[addr] <= wdata;
  end

  // R5
  ack_matches_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackBit == reqBit);

  // R8
  oor_load_zero_chk: assert property (@(negedge clk) disable iff (!rstN)
    (active && !wrEn && !inRange) |=> (rdData == '0));
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath #(
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 5,
  parameter int NREGS  = 8,
  parameter int IDX_W  = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seq_pkg::seqStrobe_t        strb,
  input  logic [ADDR_W-1:0]          cmdAddr,
  input  logic [seq_pkg::WORD_W-1:0] cmdWdata,
  input  logic [IDX_W-1:0]           cmdDest,
  input  logic [IDX_W-1:0]           rfIdx,
  output logic [seq_pkg::WORD_W-1:0] rfData
);
  import seq_pkg::*;

  logic              reqBit;
  logic              wrEnQ;
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] wdataQ;
  logic [IDX_W-1:0]  destQ;
  logic [WORD_W-1:0] ramRd;
  logic [WORD_W-1:0] regFile [NREGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqBit <= 1'b0;
      wrEnQ  <= 1'b0;
      addrQ  <= '0;
      wdataQ <= '0;
      destQ  <= '0;
    end else if (strb.issue) begin
      reqBit <= ~reqBit;
      wrEnQ  <= strb.isStore;
      addrQ  <= cmdAddr;
      wdataQ <= cmdWdata;
      destQ  <= cmdDest;
    end
  end

  seq_stack_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_ram (
    .clk    (clk),
    .rstN   (rstN),
    .reqBit (reqBit),
    .wrEn   (wrEnQ),
    .addr   (addrQ),
    .wdata  (wdataQ),
    .rdData (ramRd)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) regFile[i] <= '0;
    end else if (strb.capture) begin
      regFile[destQ] <= ramRd;
    end
  end

  always_comb begin
    rfData = '0;
    if ({1'b0, rfIdx} < (IDX_W + 1)'(NREGS)) rfData = regFile[rfIdx];
  end

  // R5
  req_only_on_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.issue |=> $stable(reqBit));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic                cmdIsStore,
  output logic                cmdReady,
  output logic                busy,
  output logic                done,
  output seq_pkg::seqStrobe_t strb
);
  import seq_pkg::*;

  seqState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE:   if (cmdValid) stateNxt = cmdIsStore ? S_ST_ACT : S_LD_ACT;
      S_ST_ACT: stateNxt = S_IDLE;
      S_LD_ACT: stateNxt = S_LD_CAP;
      S_LD_CAP: stateNxt = S_IDLE;
      default:  stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= (state == S_ST_ACT) || (state == S_LD_CAP);
    end
  end

  assign cmdReady     = (state == S_IDLE);
  assign busy         = (state != S_IDLE);
  assign strb.issue   = cmdReady && cmdValid;
  assign strb.isStore = cmdIsStore;
  assign strb.capture = (state == S_LD_CAP);

  // R3
  store_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdIsStore) |=> busy ##1 (done && !busy));

  // R4
  load_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !cmdIsStore) |=> busy ##1 busy ##1 (done && !busy));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/toggle_seq_top.sv
module toggle_seq_top #(
  parameter int DEPTH  = 24,
  parameter int NREGS  = 8,
  parameter int ADDR_W = $clog2(DEPTH + 1),
  parameter int IDX_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdIsStore,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [31:0]       cmdWdata,
  input  logic [IDX_W-1:0]  cmdDest,
  output logic              busy,
  output logic              done,
  input  logic [IDX_W-1:0]  rfIdx,
  output logic [31:0]       rfData
);
  import seq_pkg::*;

  seqStrobe_t strb;

  seq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdIsStore (cmdIsStore),
    .cmdReady   (cmdReady),
    .busy       (busy),
    .done       (done),
    .strb       (strb)
  );

  seq_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .NREGS(NREGS), .IDX_W(IDX_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdAddr  (cmdAddr),
    .cmdWdata (cmdWdata),
    .cmdDest  (cmdDest),
    .rfIdx    (rfIdx),
    .rfData   (rfData)
  );
endmodule

// File: tb/test_toggle_seq_top.sv
`timescale 1ns/1ps
module test_toggle_seq_top;
  localparam int DEPTH  = 24;
  localparam int NREGS  = 8;
  localparam int ADDR_W = $clog2(DEPTH + 1);
  localparam int IDX_W  = $clog2(NREGS);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic              cmdReady;
  logic              cmdIsStore = 1'b0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [31:0]       cmdWdata = '0;
  logic [IDX_W-1:0]  cmdDest = '0;
  logic              busy, done;
  logic [IDX_W-1:0]  rfIdx = '0;
  logic [31:0]       rfData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [31:0] shMem [DEPTH];
  logic [31:0] shReg [NREGS];

  always #10 clk = ~clk;

  toggle_seq_top #(.DEPTH(DEPTH), .NREGS(NREGS)) i_toggle_seq_top (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdIsStore(cmdIsStore), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .cmdDest(cmdDest), .busy(busy), .done(done), .rfIdx(rfIdx), .rfData(rfData)
  );

  function automatic logic [31:0] expLoad(input logic [ADDR_W-1:0] a);
    return ({1'b0, a} < (ADDR_W + 1)'(DEPTH)) ? shMem[a] : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic stepEdge();
    @(posedge clk);
    #5;
  endtask

  task automatic readReg(input logic [IDX_W-1:0] idx, output logic [31:0] val);
    rfIdx = idx;
    #1;
    val = rfData;
  endtask

  task automatic doStore(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    cmdValid = 1'b1; cmdIsStore = 1'b1; cmdAddr = a; cmdWdata = d;
    cmdDest = IDX_W'($urandom);
    stepEdge();
    cmdValid = 1'b0;
    check("R3 busy after accept", {31'b0, busy}, 32'd1);
    check("R2 ready while busy", {31'b0, cmdReady}, 32'd0);
    stepEdge();
    check("R3 busy cleared", {31'b0, busy}, 32'd0);
    check("R3 done", {31'b0, done}, 32'd1);
    if ({1'b0, a} < (ADDR_W + 1)'(DEPTH)) shMem[a] = d;
  endtask

  task automatic doLoad(input logic [ADDR_W-1:0] a, input logic [IDX_W-1:0] dst,
                        input string req);
    logic [31:0] v;
    logic [IDX_W-1:0] other;
    cmdValid = 1'b1; cmdIsStore = 1'b0; cmdAddr = a; cmdDest = dst;
    cmdWdata = $urandom;
    stepEdge();
    cmdValid = 1'b0;
    check("R4 busy first cycle", {31'b0, busy}, 32'd1);
    stepEdge();
    check("R4 busy second cycle", {31'b0, busy}, 32'd1);
    check("R2 ready while busy", {31'b0, cmdReady}, 32'd0);
    check("R10 no early done", {31'b0, done}, 32'd0);
    stepEdge();
    check("R4 busy cleared", {31'b0, busy}, 32'd0);
    check("R4 done", {31'b0, done}, 32'd1);
    shReg[dst] = expLoad(a);
    readReg(dst, v);
    check(req, v, shReg[dst]);
    other = dst + IDX_W'(1);
    readReg(other, v);
    check("R9 other register kept", v, shReg[other]);
    stepEdge();
    check("R10 done single pulse", {31'b0, done}, 32'd0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NREGS; i++) shReg[i] = 32'h0;
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
    stepEdge();
    // R1 reset state
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 ready", {31'b0, cmdReady}, 32'd1);
    for (int i = 0; i < NREGS; i++) begin
      readReg(IDX_W'(i), v);
      check("R1 register cleared", v, 32'h0);
    end
    // seed every word
    for (int a = 0; a < DEPTH; a++) doStore(ADDR_W'(a), $urandom);
    // R6 directed loads at the ends of the array
    doLoad(ADDR_W'(0), 3'd0, "R6 load address zero");
    doLoad(ADDR_W'(DEPTH - 1), 3'd7, "R6 load top address");
    // R7 load right after store, same address
    doStore(ADDR_W'(5), 32'hDEAD_BEEF);
    doLoad(ADDR_W'(5), 3'd2, "R7 load after store");
    // R5 idle inputs have no effect
    cmdIsStore = 1'b1; cmdAddr = ADDR_W'(5); cmdWdata = 32'h1234_5678;
    repeat (4) stepEdge();
    doLoad(ADDR_W'(5), 3'd4, "R5 idle inputs ignored");
    // R8 out-of-range store and load
    doStore(ADDR_W'(DEPTH), 32'hCAFE_F00D);
    doLoad(ADDR_W'(DEPTH), 3'd1, "R8 out-of-range load gives zero");
    doStore(ADDR_W'((1 << ADDR_W) - 1), 32'h0BAD_0BAD);
    for (int a = 0; a < DEPTH; a++)
      doLoad(ADDR_W'(a), IDX_W'(a), "R8 array untouched by far store");
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [ADDR_W-1:0] ra;
      ra = ADDR_W'($urandom_range(0, (1 << ADDR_W) - 1));
      if ($urandom_range(0, 1) == 1) doStore(ra, $urandom);
      else doLoad(ra, IDX_W'($urandom), "R6 random load");
      if ($urandom_range(0, 3) == 0) stepEdge();
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule